// File: doc/BRIEF.md
# Reloading Down-Counter Timer Bank

A bank of three interrupting down-counters and one wide up-counting free-running counter. All of them sit behind a simple word-addressed register port. Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. They decrement once per pulse of a shared slow tick-enable. When a count passes zero, the channel either reloads from its load register (periodic mode) or wraps to all ones (free mode). In both modes it latches an interrupt, which software drops by writing to that channel's clear register. Loading N-1 in periodic mode gives an interrupt every N slow ticks.

The fourth counter is 40 bits wide and counts up on its own faster tick-enable. It has no interrupt. Software enables it through a bit in its high-word register, and reads the count as a low word and a high word. Both words can be preset by a write, which lets software seed the count.

Top module: `tick_timer_bank`

## Requirements
- R1: Channels 0 and 1 hold 16-bit load and count values, and channel 2 holds 32-bit ones. A wider load write is truncated, and reads are zero-extended to 32 bits.
- R2: Channel i has its registers at byte offset 0x20*i: load at +0x0, count at +0x4 (read-only), control at +0x8 and clear at +0xC. In the control register, bit 7 is enable and bit 6 is periodic. The free counter's low word is at 0x60 and its high word is at 0x64. The clear register and any unmapped address read as zero.
- R3: A load write to a disabled channel sets its count at once. A channel changes its count only on a slow_tick cycle while it is enabled.
- R4: In periodic mode, a tick that finds the count at zero reloads it from the load register and latches the interrupt, so a load of L gives a period of L+1 ticks.
- R5: In free mode, a tick that finds the count at zero wraps it to all ones and latches the interrupt.
- R6: A write of any value to a channel's clear register drops its interrupt in the next cycle. An underflow in that same cycle wins, and the interrupt stays set.
- R7: irq_o[i] belongs to channel i and stays high until it is cleared.
- R8: A load write to an enabled channel leaves the count unchanged until the next slow tick. That tick loads the new value instead of decrementing.
- R9: The free counter increments by one per fast_tick while it is enabled, and it ignores slow_tick. While it is disabled it holds its value.
- R10: A write to the free counter's high word sets bits 39:32 from wdata[7:0] and sets the enable from wdata[8]. A write to the low word sets bits 31:0. The count wraps from all ones to zero, and the free counter never drives an interrupt.
- R11: After reset, all counts and load values are zero, every counter is disabled, and no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| slow_tick | input | 1 | Tick-enable for channels 0 to 2 |
| fast_tick | input | 1 | Tick-enable for the free counter |
| irq_o | output | 3 | Latched interrupts, one per channel |

## Verification
The hardest situation to reach from the ports is the free counter carrying out of its low word and wrapping at 2^40. At the tick rate this would take billions of cycles. The stimulus reaches it by presetting the low word to just below all ones and the high byte to its maximum, then applying a few fast ticks. A second hard case is a clear write that lands in the same cycle as an underflow. The bench reaches it by running a channel with a load of zero, so that every tick underflows, and then asserting the clear write and the tick together.

// File: rtl/tick_timer_pkg.sv
// Shared constants for the timer bank: register offsets and control bits.
package tick_timer_pkg;
    localparam int NUM_CH       = 3;
    localparam int BUS_W        = 32;
    localparam int CH_STRIDE    = 32;
    localparam int OFS_LOAD     = 0;
    localparam int OFS_VALUE    = 4;
    localparam int OFS_CTRL     = 8;
    localparam int OFS_CLEAR    = 12;
    localparam int FREE_LO_ADR  = 96;
    localparam int FREE_HI_ADR  = 100;
    localparam int CTRL_EN_BIT  = 7;
    localparam int CTRL_PER_BIT = 6;
    localparam int FREE_EN_BIT  = 8;
endpackage

// File: rtl/tick_timer_chan.sv
// One reloadable down-counter channel.
// Assumes: tick is a one-cycle enable pulse; the write strobes are already decoded.
module tick_timer_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_load,
    input  logic         wr_ctrl,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    input  logic         en_in,
    input  logic         per_in,
    output logic [W-1:0] load_q,
    output logic [W-1:0] count_q,
    output logic         en_q,
    output logic         per_q,
    output logic         irq_q
);
    logic pend_q;

    // Control, load, count, reload-pending and interrupt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= '0;
            count_q <= '0;
            en_q    <= 1'b0;
            per_q   <= 1'b0;
            irq_q   <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= en_in;
                per_q <= per_in;
            end
            if (wr_clr) begin
                irq_q <= 1'b0;
            end
            if (tick && en_q) begin
                if (pend_q) begin
                    count_q <= load_q;
                    pend_q  <= 1'b0;
                end else if (count_q == '0) begin
                    count_q <= per_q ? load_q : '1;
                    irq_q   <= 1'b1;
                end else begin
                    count_q <= count_q - 1'b1;
                end
            end
            if (wr_load) begin
                load_q <= wdata;
                if (en_q) begin
                    pend_q <= 1'b1;
                end else begin
                    count_q <= wdata;
                end
            end
        end
    end
endmodule

// File: rtl/tick_timer_free.sv
// Wide up-counting free-running counter with a presettable low and high word.
// Assumes: FREE_W is between 33 and 40, so the high part fits below the enable bit.
module tick_timer_free #(
    parameter int FREE_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [31:0]       wdata,
    output logic [FREE_W-1:0] cnt_q,
    output logic              en_q
);
    import tick_timer_pkg::*;
    localparam int HI_W = FREE_W - 32;

    // Count and enable; a bus write takes priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (wr_hi) begin
            cnt_q[FREE_W-1:32] <= wdata[HI_W-1:0];
            en_q               <= wdata[FREE_EN_BIT];
        end else if (wr_lo) begin
            cnt_q[31:0] <= wdata;
        end else if (tick && en_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tick_timer_bank.sv
// Timer bank top: address decode, three down-counter channels and one free counter.
// Assumes: byte addresses are word aligned; reads are combinational.
module tick_timer_bank #(
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int FREE_W   = 40,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              slow_tick,
    input  logic              fast_tick,
    output logic [2:0]        irq_o
);
    import tick_timer_pkg::*;

    logic [31:0]       ld_rd  [NUM_CH];
    logic [31:0]       cnt_rd [NUM_CH];
    logic [NUM_CH-1:0] en_rd;
    logic [NUM_CH-1:0] per_rd;
    logic [FREE_W-1:0] free_cnt;
    logic              free_en;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int CW = (i == NUM_CH - 1) ? WIDE_W : NARROW_W;
        localparam int BASE = i * CH_STRIDE;
        logic [CW-1:0] ld_w;
        logic [CW-1:0] cnt_w;
        logic          wr_ld_w, wr_ct_w, wr_cl_w;

        // Per-channel write decode.
        always_comb begin
            wr_ld_w = wr_en && (addr == ADDR_W'(BASE + OFS_LOAD));
            wr_ct_w = wr_en && (addr == ADDR_W'(BASE + OFS_CTRL));
            wr_cl_w = wr_en && (addr == ADDR_W'(BASE + OFS_CLEAR));
        end

        tick_timer_chan #(.W(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (slow_tick),
            .wr_load (wr_ld_w),
            .wr_ctrl (wr_ct_w),
            .wr_clr  (wr_cl_w),
            .wdata   (wdata[CW-1:0]),
            .en_in   (wdata[CTRL_EN_BIT]),
            .per_in  (wdata[CTRL_PER_BIT]),
            .load_q  (ld_w),
            .count_q (cnt_w),
            .en_q    (en_rd[i]),
            .per_q   (per_rd[i]),
            .irq_q   (irq_o[i])
        );

        assign ld_rd[i]  = 32'(ld_w);
        assign cnt_rd[i] = 32'(cnt_w);
    end

    logic wr_free_lo, wr_free_hi;

    // Free counter write decode.
    always_comb begin
        wr_free_lo = wr_en && (addr == ADDR_W'(FREE_LO_ADR));
        wr_free_hi = wr_en && (addr == ADDR_W'(FREE_HI_ADR));
    end

    tick_timer_free #(.FREE_W(FREE_W)) u_free (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (fast_tick),
        .wr_lo (wr_free_lo),
        .wr_hi (wr_free_hi),
        .wdata (wdata),
        .cnt_q (free_cnt),
        .en_q  (free_en)
    );

    // Read multiplexer; unmapped and clear addresses return zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i * CH_STRIDE + OFS_LOAD))  rdata = ld_rd[i];
            if (addr == ADDR_W'(i * CH_STRIDE + OFS_VALUE)) rdata = cnt_rd[i];
            if (addr == ADDR_W'(i * CH_STRIDE + OFS_CTRL))
                rdata = (32'(en_rd[i]) << CTRL_EN_BIT) | (32'(per_rd[i]) << CTRL_PER_BIT);
        end
        if (addr == ADDR_W'(FREE_LO_ADR)) rdata = free_cnt[31:0];
        if (addr == ADDR_W'(FREE_HI_ADR))
            rdata = 32'(free_cnt[FREE_W-1:32]) | (32'(free_en) << FREE_EN_BIT);
    end
endmodule

// File: rtl/tick_timer_bank_chk.sv
// Checker for the timer bank: interrupt latching and clearing, free counter stepping, reset.
module tick_timer_bank_chk #(
    parameter int FREE_W = 40,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              slow_tick,
    input logic              fast_tick,
    input logic [2:0]        irq_o,
    input logic [FREE_W-1:0] free_cnt
);
    import tick_timer_pkg::*;

    logic free_wr;
    assign free_wr = wr_en && (addr == ADDR_W'(FREE_LO_ADR) || addr == ADDR_W'(FREE_HI_ADR));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_irq
        logic clr_wr;
        assign clr_wr = wr_en && (addr == ADDR_W'(i * CH_STRIDE + OFS_CLEAR));

        // R6: a clear write with no tick drops the interrupt.
        p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && !slow_tick) |=> !irq_o[i]);
        // R7: the interrupt holds until it is cleared.
        p_irq_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[i] && !clr_wr) |=> irq_o[i]);
    end

    // R3: no new interrupt rises without a slow tick.
    p_no_tick_no_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_tick |=> ((irq_o & ~$past(irq_o)) == 3'b000));
    // R9: no fast tick and no write, so the free count holds.
    p_free_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_tick && !free_wr) |=> $stable(free_cnt));
    // R10: the free count moves by at most one per cycle, with wrap.
    p_free_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_tick && !free_wr) |=>
            (free_cnt == $past(free_cnt) || free_cnt == FREE_W'($past(free_cnt) + 1'b1)));
    // R11: reset clears interrupts and the free count.
    p_reset_state_r11: assert property (@(posedge clk)
        !rst_n |=> (irq_o == 3'b000 && free_cnt == '0));
endmodule

bind tick_timer_bank tick_timer_bank_chk #(.FREE_W(FREE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .slow_tick (slow_tick),
    .fast_tick (fast_tick),
    .irq_o     (irq_o),
    .free_cnt  (free_cnt)
);

// File: tb/tick_timer_bank_bench.sv
`timescale 1ns/1ps
// Bench for the timer bank: a vector table of channel runs, then directed corner tests.
module tick_timer_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        slow_tick = 1'b0;
    logic        fast_tick = 1'b0;
    logic [2:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tick_timer_bank u_tick_timer_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .slow_tick(slow_tick), .fast_tick(fast_tick), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic        per;
        logic [31:0] load;
        logic [7:0]  ticks;
        logic [31:0] exp_val;
        logic        exp_irq;
    } vec_t;

    // Expected count: periodic gives load - ticks mod (load+1); free mode is a plain decrement mod 2^W.
    localparam vec_t VECS [8] = '{
        '{2'd0, 1'b1, 32'd4,    8'd3,  32'd1,          1'b0},
        '{2'd0, 1'b1, 32'd4,    8'd5,  32'd4,          1'b1},
        '{2'd0, 1'b1, 32'd4,    8'd7,  32'd2,          1'b1},
        '{2'd1, 1'b1, 32'd0,    8'd3,  32'd0,          1'b1},
        '{2'd1, 1'b0, 32'd2,    8'd3,  32'h0000_FFFF,  1'b1},
        '{2'd1, 1'b0, 32'd2,    8'd2,  32'd0,          1'b0},
        '{2'd2, 1'b1, 32'h10,   8'd20, 32'd13,         1'b1},
        '{2'd2, 1'b0, 32'd1,    8'd2,  32'hFFFF_FFFF,  1'b1}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; slow_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; slow_tick = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic slow(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic fast(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); fast_tick = 1'b1;
            @(negedge clk); fast_tick = 1'b0;
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state.
        chk("R11 irq", 64'(irq_o), 64'h0);
        for (int c = 0; c < 3; c++) begin
            rd(8'(c * 32 + 4), v); chk("R11 count", 64'(v), 64'h0);
            rd(8'(c * 32 + 0), v); chk("R11 load", 64'(v), 64'h0);
            rd(8'(c * 32 + 8), v); chk("R11 ctrl", 64'(v), 64'h0);
        end
        rd(8'h64, v); chk("R11 free hi", 64'(v), 64'h0);
        // R2: unmapped and clear addresses read zero.
        rd(8'h70, v); chk("R2 unmapped", 64'(v), 64'h0);

        // R4 R5 R7 R6: vector table.
        for (int i = 0; i < 8; i++) begin
            b = 8'(VECS[i].ch) * 8'd32;
            wr(b + 8'h8, 32'h0);
            wr(b + 8'hC, 32'h0);
            wr(b + 8'h0, VECS[i].load);
            wr(b + 8'h8, VECS[i].per ? 32'hC0 : 32'h80);
            slow(int'(VECS[i].ticks));
            rd(b + 8'h4, v);
            chk(VECS[i].per ? "R4 count" : "R5 count", 64'(v), 64'(VECS[i].exp_val));
            chk("R7 irq", 64'(irq_o[VECS[i].ch]), 64'(VECS[i].exp_irq));
            wr(b + 8'h8, 32'h0);
            wr(b + 8'hC, 32'h1234);
            chk("R6 clear", 64'(irq_o), 64'h0);
        end

        // R1: truncation to 16 bits.
        wr(8'h00, 32'h0001_2345);
        rd(8'h00, v); chk("R1 load trunc", 64'(v), 64'h2345);
        rd(8'h04, v); chk("R1 count trunc", 64'(v), 64'h2345);
        rd(8'h0C, v); chk("R2 clear reads zero", 64'(v), 64'h0);

        // R8: load write while enabled.
        wr(8'h00, 32'd9);
        wr(8'h08, 32'hC0);
        rd(8'h08, v); chk("R2 ctrl readback", 64'(v), 64'hC0);
        slow(2);
        rd(8'h04, v); chk("R3 enabled count", 64'(v), 64'd7);
        wr(8'h00, 32'd3);
        rd(8'h04, v); chk("R8 count held", 64'(v), 64'd7);
        slow(1);
        rd(8'h04, v); chk("R8 reload on tick", 64'(v), 64'd3);
        slow(1);
        rd(8'h04, v); chk("R8 then decrement", 64'(v), 64'd2);

        // R3: a disabled channel ignores ticks.
        wr(8'h08, 32'h0);
        slow(3);
        rd(8'h04, v); chk("R3 disabled hold", 64'(v), 64'd2);

        // R6: underflow in the same cycle as a clear keeps the interrupt.
        wr(8'h20, 32'd0);
        wr(8'h28, 32'hC0);
        slow(1);
        chk("R4 load zero irq", 64'(irq_o), 64'h2);
        repeat (4) @(negedge clk);
        chk("R7 held", 64'(irq_o), 64'h2);
        wr_tick(8'h2C, 32'h0);
        chk("R6 underflow wins", 64'(irq_o), 64'h2);
        wr(8'h28, 32'h0);
        wr(8'h2C, 32'h0);
        chk("R6 clear after", 64'(irq_o), 64'h0);

        // R9: the free counter held while disabled, despite slow ticks.
        rd(8'h60, v); chk("R9 disabled free", 64'(v), 64'h0);
        wr(8'h64, 32'h100);
        fast(5);
        rd(8'h60, v); chk("R9 count up", 64'(v), 64'd5);
        rd(8'h64, v); chk("R10 hi readback", 64'(v), 64'h100);
        slow(2);
        rd(8'h60, v); chk("R9 ignores slow", 64'(v), 64'd5);

        // R10: carry into the high word, and the 40-bit wrap.
        wr(8'h60, 32'hFFFF_FFFE);
        fast(3);
        rd(8'h60, v); chk("R10 low after carry", 64'(v), 64'd1);
        rd(8'h64, v); chk("R10 high after carry", 64'(v), 64'h101);
        wr(8'h64, 32'h1FF);
        wr(8'h60, 32'hFFFF_FFFF);
        fast(1);
        rd(8'h60, v); chk("R10 wrap low", 64'(v), 64'h0);
        rd(8'h64, v); chk("R10 wrap high", 64'(v), 64'h100);
        chk("R10 no irq", 64'(irq_o), 64'h0);
        wr(8'h64, 32'h0);
        fast(2);
        rd(8'h60, v); chk("R9 stopped", 64'(v), 64'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule